// File: doc/BRIEF.md
# PCI Function Configuration Register File

This block holds the 256-byte configuration space of a single PCI function. A byte-addressed access port gives an 8-bit offset, a length of 1, 2 or 4 bytes and, for writes, a 32-bit data word. Read data comes back one cycle later in little-endian lane order, so the byte at the requested offset sits in bits 7:0. The identity fields are set at build time and are read-only. The command word and the general bytes can be written. Six base address registers and an expansion ROM base register hold addresses that are aligned to region sizes fixed at build time.

The block decodes the programmed base registers into address windows. A probe address input is compared against every enabled window, and the block drives one match bit per I/O window, one per memory window and one for the ROM window. When the block is built as a bridge function, it also keeps the secondary bus number that software writes to it. Higher-level logic uses the match outputs to claim accesses, and uses the bus number to route them downstream.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, offsets 0x00–0x01 read the vendor ID, 0x02–0x03 the device ID, 0x0A–0x0B the class code, 0x0E the header type and 0x3D the interrupt pin. Each implemented I/O base register reads 0x00000001. Every other byte reads zero, the secondary bus number is zero and no match output is set.
- R2: A read request is answered one cycle later with `acc_rvalid` high. Byte offset+k of the space appears in bits 8k+7:8k. Lanes that are not read return zero. A write produces no `acc_rvalid`.
- R3: A 4-byte read returns all four bytes only when the offset is at most 0xFC. Otherwise it returns two bytes if the offset is at most 0xFE, and one byte if not. A 2-byte read at 0xFF returns one byte. Lengths other than 1 or 2 act as 4.
- R4: A write of n bytes stores data byte k at offset+k, in rising offset order. Any byte that would fall past offset 0xFF is dropped and does not wrap.
- R5: Writes to the bytes at 0x00–0x03, 0x0A, 0x0B, 0x0E and 0x3D are ignored. Writes to the other general bytes, including the interrupt line at 0x3C and the command word at 0x04, are stored.
- R6: A 4-byte write at exactly 0x10+4n stores the data ANDed with ~(size−1) into base register n. An I/O base then has bit 0 forced to 1 and bit 1 forced to 0. A memory base has bits 3:0 forced to 0. An unimplemented base register always reads 0. Writes of any other length or alignment to base register bytes 0x10–0x27 or 0x30–0x33 are ignored.
- R7: A 4-byte write at exactly 0x30 stores the data ANDed with ~(size−1) into the ROM base register, and keeps data bit 0 as the ROM enable. Bits 10:1 read zero.
- R8: I/O match bit n is high only when command bit 0 is set, base register n is an implemented I/O register, and the probe address lies in [base, base+size−1].
- R9: Memory match bit n is high only when command bit 1 is set, base register n is an implemented memory register, and the probe lies inside its window.
- R10: The ROM match is high only when command bit 1 is set, ROM register bit 0 is 1, and the probe lies in [ROM base, ROM base+size−1].
- R11: A write that changes a base register or the command word changes the match outputs one cycle after the clock edge that stores the write, not at that edge.
- R12: On a bridge build, any write at offset 0x19 loads the secondary bus number from data bits 7:0. A write of 2 or more bytes at offset 0x18 loads it from data bits 15:8. A 1-byte write at 0x18 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_off | input | 8 | Byte offset into the space |
| acc_len | input | 3 | Access length in bytes (1, 2 or 4) |
| acc_wdata | input | 32 | Write data, little-endian lanes |
| acc_rdata | output | 32 | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read data valid, one cycle after the request |
| probe_addr | input | 32 | Address compared against the decoded windows |
| io_hit | output | 6 | Per base register I/O window match |
| mem_hit | output | 6 | Per base register memory window match |
| rom_hit | output | 1 | Expansion ROM window match |
| sec_bus | output | 8 | Captured secondary bus number |

## Verification
The bench targets the end of the space. A 4-byte read at 0xFD or 0xFF checks whether the design returns stray upper lanes, and a write at 0xFE checks whether the design wraps into the identity bytes or loses the final byte. Base register writes use all-ones and unaligned values, so a design that forgets the size mask or the forced type bits reads back the wrong low bits. Window checks probe both ends of each range, check the cycle right after a write, and toggle each command bit and the ROM enable on its own. A design that updates a window too early, or ignores one of the gates, raises a match at the wrong time. The secondary bus checks compare a 1-byte write at 0x18 against wider writes there, which catches a design that loads the number from the wrong lane.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  typedef enum logic [1:0] {SLOT_NONE, SLOT_IO, SLOT_MEM, SLOT_ROM} slot_kind_e;

  localparam int          NUM_BARS   = 6;
  localparam logic [7:0]  OFF_BAR0   = 8'h10;
  localparam logic [7:0]  OFF_ROM    = 8'h30;
  localparam logic [7:0]  OFF_CMD    = 8'h04;
  localparam logic [7:0]  OFF_BUSLO  = 8'h18;
  localparam logic [7:0]  OFF_SECBUS = 8'h19;

  // Map a requested length to 1, 2 or 4.
  function automatic logic [2:0] norm_len(input logic [2:0] len);
    if (len == 3'd1 || len == 3'd2) return len;
    return 3'd4;
  endfunction

  // Number of bytes a write stores: never past 0xFF.
  function automatic logic [2:0] write_count(input logic [7:0] off, input logic [2:0] len);
    logic [8:0] room;
    room = 9'd256 - {1'b0, off};
    if ({6'd0, norm_len(len)} > room) return room[2:0];
    return norm_len(len);
  endfunction

  // Number of bytes a read returns after narrowing near the top.
  function automatic logic [2:0] read_count(input logic [7:0] off, input logic [2:0] len);
    logic [2:0] n;
    n = norm_len(len);
    if (n == 3'd4 && off <= 8'hFC) return 3'd4;
    if (n != 3'd1 && off <= 8'hFE) return 3'd2;
    return 3'd1;
  endfunction

  function automatic logic [31:0] size_mask(input logic [4:0] lg);
    return 32'hFFFF_FFFF << lg;
  endfunction

  function automatic logic is_ro_byte(input logic [7:0] a);
    return (a <= 8'h03) || (a == 8'h0A) || (a == 8'h0B) || (a == 8'h0E) || (a == 8'h3D);
  endfunction

  function automatic logic is_base_byte(input logic [7:0] a);
    return (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
  endfunction

  // Value a base register keeps after a write of v.
  function automatic logic [31:0] base_store(input logic [31:0] v, input logic [4:0] lg,
                                             input slot_kind_e kind);
    logic [31:0] m;
    m = v & size_mask(lg);
    case (kind)
      SLOT_IO:  return {m[31:2], 2'b01};
      SLOT_MEM: return {m[31:4], 4'b0000};
      SLOT_ROM: return {m[31:11], 10'd0, v[0]};
      default:  return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/cfgsp_byte_file.sv
module cfgsp_byte_file
  import cfgsp_pkg::*;
#(
  parameter logic [15:0] VENDOR   = 16'hA5C3,
  parameter logic [15:0] DEVICE   = 16'h0917,
  parameter logic [15:0] CLASS    = 16'h0604,
  parameter logic [7:0]  HDR_TYPE = 8'h01,
  parameter logic [7:0]  INT_PIN  = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       off,
  input  logic [2:0]       nbytes,
  input  logic [31:0]      wdata,
  output logic [3:0][7:0]  rd_bytes,
  output logic [7:0]       cmd_byte
);
  localparam int DEPTH = 256;

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] lane_hit;
  logic [1:0]       lane_sel [DEPTH];
  logic [3:0][7:0]  wbytes;

  assign wbytes = wdata;

  function automatic logic [7:0] reset_val(input logic [7:0] a);
    case (a)
      8'h00:   return VENDOR[7:0];
      8'h01:   return VENDOR[15:8];
      8'h02:   return DEVICE[7:0];
      8'h03:   return DEVICE[15:8];
      8'h0A:   return CLASS[7:0];
      8'h0B:   return CLASS[15:8];
      8'h0E:   return HDR_TYPE;
      8'h3D:   return INT_PIN;
      default: return 8'h00;
    endcase
  endfunction

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      lane_sel[j] = 2'(8'(j) - off);
      lane_hit[j] = wr_en && (8'(8'(j) - off) < {5'd0, nbytes}) &&
                    !is_ro_byte(8'(j)) && !is_base_byte(8'(j));
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < DEPTH; j++) begin
      if (!rst_n)           mem[j] <= reset_val(8'(j));
      else if (lane_hit[j]) mem[j] <= wbytes[lane_sel[j]];
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) rd_bytes[k] = mem[8'(off + 8'(k))];
  end

  assign cmd_byte = mem[OFF_CMD];

endmodule

// File: rtl/cfgsp_bar_slot.sv
module cfgsp_bar_slot
  import cfgsp_pkg::*;
#(
  parameter slot_kind_e KIND = SLOT_NONE,
  parameter logic [4:0] LG   = 5'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic [31:0] wr_val,
  input  logic        space_en,
  input  logic [31:0] probe_addr,
  output logic [31:0] reg_val,
  output logic        hit
);
  localparam logic [31:0] MASK  = size_mask(LG);
  localparam logic [31:0] RST_V = (KIND == SLOT_IO) ? 32'd1 : 32'd0;
  localparam logic        LIVE  = (KIND != SLOT_NONE);

  logic [31:0] reg_q;
  logic [31:0] win_base_q;
  logic        win_on_q;
  logic        win_on_d;

  always_ff @(posedge clk) begin
    if (!rst_n)                reg_q <= RST_V;
    else if (wr_stb && LIVE)   reg_q <= base_store(wr_val, LG, KIND);
  end

  assign win_on_d = LIVE && space_en && ((KIND != SLOT_ROM) || reg_q[0]);

  // Window registers lag the config state by one cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_on_q   <= 1'b0;
      win_base_q <= 32'd0;
    end else begin
      win_on_q   <= win_on_d;
      win_base_q <= reg_q & MASK;
    end
  end

  assign hit     = win_on_q && ((probe_addr & MASK) == win_base_q);
  assign reg_val = reg_q;

  // R8 / R9: a match needs the space enable from the cycle before.
  p_hit_needs_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(space_en));

  generate
    if (KIND == SLOT_IO) begin : g_io_chk
      p_io_type_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (reg_q[1:0] == 2'b01));
    end else if (KIND == SLOT_MEM) begin : g_mem_chk
      p_mem_type_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (reg_q[3:0] == 4'd0));
    end else if (KIND == SLOT_ROM) begin : g_rom_chk
      p_rom_enable_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(reg_q[0]));
    end
  endgenerate

endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfgsp_pkg::*;
#(
  parameter logic [15:0] VENDOR    = 16'hA5C3,
  parameter logic [15:0] DEVICE    = 16'h0917,
  parameter logic [15:0] CLASS     = 16'h0604,
  parameter logic [7:0]  HDR_TYPE  = 8'h01,
  parameter logic [7:0]  INT_PIN   = 8'h01,
  parameter bit          IS_BRIDGE = 1'b1,
  // log2 size per base register, index 0 in the low bits; 0 = not implemented.
  // I/O needs at least 2, memory at least 4, ROM at least 11.
  parameter logic [NUM_BARS*5-1:0] BAR_LG = {5'd0, 5'd0, 5'd0, 5'd20, 5'd12, 5'd8},
  parameter logic [NUM_BARS-1:0]   BAR_IO = 6'b000001,
  parameter logic [4:0]            ROM_LG = 5'd16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [7:0]          acc_off,
  input  logic [2:0]          acc_len,
  input  logic [31:0]         acc_wdata,
  output logic [31:0]         acc_rdata,
  output logic                acc_rvalid,
  input  logic [31:0]         probe_addr,
  output logic [NUM_BARS-1:0] io_hit,
  output logic [NUM_BARS-1:0] mem_hit,
  output logic                rom_hit,
  output logic [7:0]          sec_bus
);
  logic [2:0]               eff_len;
  logic [2:0]               wr_n;
  logic [2:0]               rd_n;
  logic                     do_wr;
  logic                     do_rd;
  logic [3:0][7:0]          file_bytes;
  logic [7:0]               cmd_byte;
  logic [NUM_BARS-1:0][31:0] bar_val;
  logic [31:0]              rom_val;
  logic [NUM_BARS-1:0]      slot_hit;
  logic                     rom_wr;
  logic [3:0][7:0]          rd_d;
  logic [31:0]              rdata_q;
  logic                     rvalid_q;
  logic [7:0]               sec_q;

  assign eff_len = norm_len(acc_len);
  assign wr_n    = write_count(acc_off, acc_len);
  assign rd_n    = read_count(acc_off, acc_len);
  assign do_wr   = acc_valid && acc_write;
  assign do_rd   = acc_valid && !acc_write;
  assign rom_wr  = do_wr && (eff_len == 3'd4) && (acc_off == OFF_ROM);

  cfgsp_byte_file #(
    .VENDOR(VENDOR), .DEVICE(DEVICE), .CLASS(CLASS),
    .HDR_TYPE(HDR_TYPE), .INT_PIN(INT_PIN)
  ) u_bytes (
    .clk(clk), .rst_n(rst_n), .wr_en(do_wr), .off(acc_off), .nbytes(wr_n),
    .wdata(acc_wdata), .rd_bytes(file_bytes), .cmd_byte(cmd_byte)
  );

  generate
    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
      localparam logic [4:0] LG = BAR_LG[g*5 +: 5];
      localparam slot_kind_e KD = (LG == 5'd0) ? SLOT_NONE :
                                  (BAR_IO[g] ? SLOT_IO : SLOT_MEM);
      logic wstb;
      assign wstb = do_wr && (eff_len == 3'd4) && (acc_off == 8'(OFF_BAR0 + 8'(4*g)));

      cfgsp_bar_slot #(.KIND(KD), .LG(LG)) u_slot (
        .clk(clk), .rst_n(rst_n), .wr_stb(wstb), .wr_val(acc_wdata),
        .space_en((KD == SLOT_IO) ? cmd_byte[0] : cmd_byte[1]),
        .probe_addr(probe_addr), .reg_val(bar_val[g]), .hit(slot_hit[g])
      );

      assign io_hit[g]  = (KD == SLOT_IO)  && slot_hit[g];
      assign mem_hit[g] = (KD == SLOT_MEM) && slot_hit[g];
    end
  endgenerate

  cfgsp_bar_slot #(.KIND(SLOT_ROM), .LG(ROM_LG)) u_rom (
    .clk(clk), .rst_n(rst_n), .wr_stb(rom_wr), .wr_val(acc_wdata),
    .space_en(cmd_byte[1]), .probe_addr(probe_addr),
    .reg_val(rom_val), .hit(rom_hit)
  );

  // Byte k of a read: base register bytes come from the slots, the rest from the file.
  always_comb begin
    for (int k = 0; k < 4; k++) begin
      logic [7:0] a;
      logic [7:0] rel;
      a   = 8'(acc_off + 8'(k));
      rel = 8'(a - OFF_BAR0);
      if (3'(k) >= rd_n)
        rd_d[k] = 8'h00;
      else if (a >= OFF_ROM && a <= 8'h33)
        rd_d[k] = rom_val[8*a[1:0] +: 8];
      else if (is_base_byte(a))
        rd_d[k] = bar_val[rel[4:2]][8*rel[1:0] +: 8];
      else
        rd_d[k] = file_bytes[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= 32'd0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= do_rd;
      if (do_rd) rdata_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sec_q <= 8'h00;
    else if (IS_BRIDGE && do_wr) begin
      if (acc_off == OFF_SECBUS)
        sec_q <= acc_wdata[7:0];
      else if (acc_off == OFF_BUSLO && eff_len != 3'd1)
        sec_q <= acc_wdata[15:8];
    end
  end

  assign acc_rdata  = rdata_q;
  assign acc_rvalid = rvalid_q;
  assign sec_bus    = sec_q;

  p_rvalid_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rvalid |-> $past(do_rd));

  p_top_byte_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && acc_off == 8'hFF) |=> (acc_rdata[31:8] == 24'd0));

  p_secbus_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_wr && (acc_off == OFF_SECBUS || acc_off == OFF_BUSLO)) |=> $stable(sec_bus));

  p_hit_kinds_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hit & mem_hit) == '0);

endmodule

// File: tb/cfg_space_regs_tb_top.sv
`timescale 1ns/1ps
module cfg_space_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [7:0]  acc_off = 8'd0;
  logic [2:0]  acc_len = 3'd4;
  logic [31:0] acc_wdata = 32'd0;
  logic [31:0] acc_rdata;
  logic        acc_rvalid;
  logic [31:0] probe_addr = 32'd0;
  logic [5:0]  io_hit;
  logic [5:0]  mem_hit;
  logic        rom_hit;
  logic [7:0]  sec_bus;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  cfg_space_regs dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_off(acc_off), .acc_len(acc_len), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid), .probe_addr(probe_addr),
    .io_hit(io_hit), .mem_hit(mem_hit), .rom_hit(rom_hit), .sec_bus(sec_bus)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wr(input logic [7:0] off, input logic [2:0] len, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_off = off; acc_len = len; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  // Driver: issue a read and push its expected value into the scoreboard.
  task automatic rd(input logic [7:0] off, input logic [2:0] len,
                    input logic [31:0] exp, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_off = off; acc_len = len;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // Monitor: pop and compare on every returned read.
  always @(negedge clk) begin
    if (rst_n && acc_rvalid) begin
      if (exp_q.size() == 0) begin
        check(acc_rdata, 32'hxxxx_xxxx, "R2 unexpected read data");
      end else begin
        check(acc_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic probe(input logic [31:0] a);
    probe_addr = a;
    #0.5;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({26'd0, io_hit}, 32'd0, "R1 io_hit after reset");
    check({26'd0, mem_hit}, 32'd0, "R1 mem_hit after reset");
    check({31'd0, rom_hit}, 32'd0, "R1 rom_hit after reset");
    check({24'd0, sec_bus}, 32'd0, "R1 sec_bus after reset");
    rd(8'h00, 3'd4, 32'h0917_A5C3, "R1 identity IDs");
    rd(8'h08, 3'd4, 32'h0604_0000, "R1 class code");
    rd(8'h0C, 3'd4, 32'h0001_0000, "R1 header type");
    rd(8'h10, 3'd4, 32'h0000_0001, "R1 io base type");
    rd(8'h14, 3'd4, 32'h0000_0000, "R1 mem base reset");
    rd(8'h30, 3'd4, 32'h0000_0000, "R1 rom reset");
    rd(8'h3C, 3'd2, 32'h0000_0100, "R1 int pin");

    // R2 lane order and no response to writes
    wr(8'h40, 3'd4, 32'h4433_2211);
    check({31'd0, acc_rvalid}, 32'd0, "R2 no rvalid after write");
    rd(8'h40, 3'd4, 32'h4433_2211, "R2 word lanes");
    rd(8'h42, 3'd1, 32'h0000_0033, "R2 byte lane 0");
    rd(8'h41, 3'd2, 32'h0000_3322, "R2 half lanes");

    // R5 read-only bytes
    wr(8'h00, 3'd4, 32'hFFFF_FFFF);
    rd(8'h00, 3'd4, 32'h0917_A5C3, "R5 ids ignore writes");
    wr(8'h3D, 3'd1, 32'h0000_00FF);
    wr(8'h3C, 3'd1, 32'h0000_005A);
    rd(8'h3C, 3'd2, 32'h0000_015A, "R5 line writable pin fixed");
    wr(8'h08, 3'd4, 32'hFFFF_FFFF);
    rd(8'h08, 3'd4, 32'h0604_FFFF, "R5 class fixed");

    // R4 writes clipped at the top
    wr(8'hFE, 3'd4, 32'hDDCC_BBAA);
    rd(8'hFE, 3'd2, 32'h0000_BBAA, "R4 top bytes stored");
    rd(8'h00, 3'd4, 32'h0917_A5C3, "R4 no wrap");

    // R3 read narrowing
    rd(8'hFC, 3'd4, 32'hBBAA_0000, "R3 word at FC");
    rd(8'hFD, 3'd4, 32'h0000_AA00, "R3 word at FD narrows");
    rd(8'hFF, 3'd4, 32'h0000_00BB, "R3 word at FF narrows");
    rd(8'hFF, 3'd2, 32'h0000_00BB, "R3 half at FF narrows");

    // R6 base registers
    wr(8'h10, 3'd4, 32'hFFFF_FFFF);
    rd(8'h10, 3'd4, 32'hFFFF_FF01, "R6 io mask and type");
    wr(8'h14, 3'd4, 32'h1234_5678);
    rd(8'h14, 3'd4, 32'h1234_5000, "R6 mem 4K mask");
    wr(8'h18, 3'd4, 32'hABCD_EFFF);
    rd(8'h18, 3'd4, 32'hABC0_0000, "R6 mem 1M mask");
    wr(8'h1C, 3'd4, 32'hFFFF_FFFF);
    rd(8'h1C, 3'd4, 32'h0000_0000, "R6 unimplemented base");
    wr(8'h10, 3'd2, 32'h0000_0000);
    rd(8'h10, 3'd4, 32'hFFFF_FF01, "R6 short write ignored");
    wr(8'h0E, 3'd4, 32'h0000_0000);
    rd(8'h10, 3'd4, 32'hFFFF_FF01, "R6 misaligned write ignored");

    // R7 ROM register
    wr(8'h30, 3'd4, 32'h0003_FFFF);
    rd(8'h30, 3'd4, 32'h0003_0001, "R7 rom mask keeps enable");

    // R8 / R11 I/O window
    wr(8'h10, 3'd4, 32'h0000_C0AB);
    probe(32'h0000_C010);
    check({26'd0, io_hit}, 32'd0, "R8 io off while cmd clear");
    wr(8'h04, 3'd2, 32'h0000_0001);
    probe(32'h0000_C010);
    check({26'd0, io_hit}, 32'd0, "R11 no change at write edge");
    @(negedge clk);
    probe(32'h0000_C010);
    check({26'd0, io_hit}, 32'd1, "R11 io on one cycle later");
    probe(32'h0000_C0FF);
    check({26'd0, io_hit}, 32'd1, "R8 io upper end");
    probe(32'h0000_C100);
    check({26'd0, io_hit}, 32'd0, "R8 io past end");
    probe(32'h0000_BFFF);
    check({26'd0, io_hit}, 32'd0, "R8 io below base");

    // R9 memory window
    probe(32'h1234_5ABC);
    check({26'd0, mem_hit}, 32'd0, "R9 mem off while cmd bit1 clear");
    wr(8'h04, 3'd1, 32'h0000_0003);
    @(negedge clk);
    probe(32'h1234_5ABC);
    check({26'd0, mem_hit}, 32'h2, "R9 mem window on");
    probe(32'h1234_6000);
    check({26'd0, mem_hit}, 32'd0, "R9 mem past end");
    probe(32'hABCF_FFFF);
    check({26'd0, mem_hit}, 32'h4, "R9 mem 1M window");

    // R10 ROM window
    probe(32'h0003_ABCD);
    check({31'd0, rom_hit}, 32'd1, "R10 rom on");
    wr(8'h30, 3'd4, 32'h0003_0000);
    @(negedge clk);
    probe(32'h0003_ABCD);
    check({31'd0, rom_hit}, 32'd0, "R10 rom enable bit clear");
    wr(8'h30, 3'd4, 32'h0003_0001);
    wr(8'h04, 3'd1, 32'h0000_0001);
    @(negedge clk);
    probe(32'h0003_ABCD);
    check({31'd0, rom_hit}, 32'd0, "R10 rom needs cmd bit1");
    probe(32'h0000_C010);
    check({26'd0, io_hit}, 32'd1, "R8 io stays with bit0");

    // R12 secondary bus number
    wr(8'h19, 3'd1, 32'h0000_0007);
    check({24'd0, sec_bus}, 32'h07, "R12 byte write at 19");
    wr(8'h18, 3'd2, 32'h0000_2A00);
    check({24'd0, sec_bus}, 32'h2A, "R12 half write at 18");
    wr(8'h18, 3'd1, 32'h0000_0055);
    check({24'd0, sec_bus}, 32'h2A, "R12 byte write at 18 ignored");
    wr(8'h18, 3'd4, 32'h0000_3C11);
    check({24'd0, sec_bus}, 32'h3C, "R12 word write at 18");

    repeat (4) @(negedge clk);
    check(32'(exp_q.size()), 32'd0, "R2 all reads answered");
    report();
  end

endmodule